// File: doc/BRIEF.md
# Boot-time SPI program image loader

This block copies a fixed-size program image out of an external SPI serial EEPROM into on-chip program RAM once, directly after reset. It selects the EEPROM and issues one read command with a 16-bit start address. It then keeps the serial clock running without a pause while the EEPROM streams the whole image back. Received bytes are packed in pairs into 16-bit words, and each word is written to the program memory write port at the next word address.

While the copy runs, the processor is held in reset and the three serial pins plus the select belong to the loader. When the last word is written, the loader deselects the EEPROM, parks the clock low, releases the processor and hands the pins back to general-purpose I/O. It signals the release with a one-cycle completion pulse. It stays idle until the next reset. It never writes to the EEPROM and has no error handling beyond the completion pulse.

Top module: `spi_boot_loader`

## Requirements
- R1: `sclk` idles low and, while the transfer runs, toggles with a period of CLK_DIV system clocks and a 50% duty cycle (default 4, i.e. 12 MHz to 3 MHz).
- R2: `ssel_n` is high during reset, falls exactly once at the start of the download, stays low for the whole transfer and rises exactly once at the end.
- R3: The first 24 bits on `mosi` are the read opcode 0x03 followed by the 16-bit start address 0x0000, each most significant bit first. After these 24 bits `mosi` stays low.
- R4: `mosi` changes only in the cycle in which `sclk` falls, and `miso` is sampled when `sclk` rises (SPI mode 0).
- R5: Data bits arrive most significant bit first. Byte 2k of the stream forms bits [7:0] of word k and byte 2k+1 forms bits [15:8].
- R6: Every word is written with a one-cycle `pmem_we` pulse. Exactly IMG_WORDS words are written, at addresses 0, 1, 2, … IMG_WORDS-1 in that order.
- R7: The clock runs without a gap: exactly 24 + 16·IMG_WORDS rising edges occur, each CLK_DIV cycles after the previous one.
- R8: `cpu_hold` and `pins_own` are high from reset until the transfer ends and are low afterwards. Every write happens while `cpu_hold` is high. After release, `sclk`=0, `mosi`=0 and `ssel_n`=1.
- R9: `done` pulses high for exactly one cycle, once, in the first cycle in which `cpu_hold` is low.
- R10: After release the block makes no further writes and no further pin activity until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts a new download when released |
| miso | input | 1 | Serial data from the EEPROM |
| ssel_n | output | 1 | Active-low EEPROM select |
| sclk | output | 1 | Serial clock to the EEPROM |
| mosi | output | 1 | Serial command/address data to the EEPROM |
| pins_own | output | 1 | High while the loader owns the serial pins; low hands them to GPIO |
| pmem_we | output | 1 | Program memory write strobe |
| pmem_addr | output | ADDR_W | Program memory word address |
| pmem_wdata | output | 16 | Program memory write data |
| cpu_hold | output | 1 | Holds the processor in reset while high |
| done | output | 1 | One-cycle pulse when the download completes |

## Verification
A miscounted bit counter moves the byte boundaries. The first written word then carries shifted data, and the error is visible at the first `pmem_we`, 24 + 16 serial clocks after the download starts. A wrong divider or a phase slip shows at once in the spacing of `sclk` rises or in a `mosi` change away from a falling edge. A wrong end condition shows at the end of the run: a write count other than IMG_WORDS, a mistimed `done`, or serial activity after release.

// File: rtl/spi_ld_pkg.sv
package spi_ld_pkg;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_RUN,
    ST_TAIL,
    ST_FIN
  } ld_state_t;

  localparam int CMD_BITS = 24;

  // command frame: opcode then 16-bit address, sent MSB first
  function automatic logic [CMD_BITS-1:0] read_frame(input logic [7:0] op,
                                                     input logic [15:0] addr);
    return {op, addr};
  endfunction

  // shift register holds first byte in [15:8], second in [7:0];
  // the first byte goes to the low half of the word
  function automatic logic [15:0] pack_word(input logic [15:0] sh);
    return {sh[7:0], sh[15:8]};
  endfunction

endpackage

// File: rtl/spi_ld_clkgen.sv
module spi_ld_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF - 1));
  assign rise_evt = wrap && !sclk;
  assign fall_evt = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_ld_shifter.sv
module spi_ld_shifter #(
  parameter logic [23:0] FRAME = 24'h030000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        miso,
  output logic        mosi_bit,
  output logic [15:0] rx_next
);
  logic [23:0] tx_sh;
  logic [15:0] rx_sh;

  assign mosi_bit = tx_sh[23];
  assign rx_next  = {rx_sh[14:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= FRAME;
      rx_sh <= '0;
    end else begin
      if (fall_evt) tx_sh <= {tx_sh[22:0], 1'b0};
      if (rise_evt) rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_ld_pkg::*;
#(
  parameter int          IMG_WORDS  = 8192,
  parameter int          CLK_DIV    = 4,
  parameter logic [7:0]  RD_OPCODE  = 8'h03,
  parameter logic [15:0] START_ADDR = 16'h0000,
  localparam int         ADDR_W     = (IMG_WORDS > 1) ? $clog2(IMG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miso,
  output logic              ssel_n,
  output logic              sclk,
  output logic              mosi,
  output logic              pins_own,
  output logic              pmem_we,
  output logic [ADDR_W-1:0] pmem_addr,
  output logic [15:0]       pmem_wdata,
  output logic              cpu_hold,
  output logic              done
);
  localparam int TOTAL_BITS = CMD_BITS + 16 * IMG_WORDS;
  localparam int BIT_W      = $clog2(TOTAL_BITS + 1);

  ld_state_t        st;
  logic [BIT_W-1:0] bit_cnt;
  logic [BIT_W-1:0] data_idx;
  logic             run, rise_evt, fall_evt, mosi_bit;
  logic             in_data, word_end, last_bit;
  logic [15:0]      rx_next;

  assign run      = (st == ST_RUN) || (st == ST_TAIL);
  assign data_idx = bit_cnt - BIT_W'(CMD_BITS);
  assign in_data  = bit_cnt >= BIT_W'(CMD_BITS);
  assign word_end = rise_evt && in_data && (data_idx[3:0] == 4'hF);
  assign last_bit = rise_evt && (bit_cnt == BIT_W'(TOTAL_BITS - 1));

  spi_ld_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  spi_ld_shifter #(.FRAME(read_frame(RD_OPCODE, START_ADDR))) shift_i (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .miso(miso), .mosi_bit(mosi_bit), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_BOOT;
      bit_cnt    <= '0;
      pmem_we    <= 1'b0;
      pmem_addr  <= '0;
      pmem_wdata <= '0;
      done       <= 1'b0;
    end else begin
      pmem_we <= 1'b0;
      done    <= 1'b0;
      unique case (st)
        ST_BOOT: st <= ST_RUN;
        ST_RUN: begin
          if (rise_evt) bit_cnt <= bit_cnt + 1'b1;
          if (word_end) begin
            pmem_we    <= 1'b1;
            pmem_addr  <= data_idx[ADDR_W+3:4];
            pmem_wdata <= pack_word(rx_next);
          end
          if (last_bit) st <= ST_TAIL;
        end
        ST_TAIL: begin
          if (fall_evt) begin
            st   <= ST_FIN;
            done <= 1'b1;
          end
        end
        default: st <= ST_FIN;
      endcase
    end
  end

  assign ssel_n   = !run;
  assign pins_own = (st != ST_FIN);
  assign cpu_hold = (st != ST_FIN);
  assign mosi     = mosi_bit && pins_own;
endmodule

// File: rtl/spi_ld_chk.sv
module spi_ld_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              ssel_n,
  input logic              mosi,
  input logic              pmem_we,
  input logic [ADDR_W-1:0] pmem_addr,
  input logic              cpu_hold,
  input logic              pins_own,
  input logic              done
);
  logic [ADDR_W-1:0] exp_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_addr <= '0;
    else if (pmem_we) exp_addr <= exp_addr + 1'b1;
  end

  // R2
  sclk_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !ssel_n);

  // R4
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $fell(sclk));

  // R6
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_we |-> (pmem_addr == exp_addr));

  // R8
  write_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_we |-> cpu_hold);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cpu_hold && !pins_own));

  // R10
  stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_own |=> (!pins_own && ssel_n && !sclk && !pmem_we));
endmodule

bind spi_boot_loader spi_ld_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi),
  .pmem_we(pmem_we), .pmem_addr(pmem_addr), .cpu_hold(cpu_hold),
  .pins_own(pins_own), .done(done)
);

// File: tb/spi_boot_loader_tb_top.sv
module spi_boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 16;
  localparam int DIV        = 4;
  localparam int AW         = $clog2(WORDS);
  localparam int NBITS      = 24 + 16 * WORDS;
  localparam int PROBE [8]  = '{0, 1, 2, 5, 7, 10, 14, 15};

  logic clk = 1'b0, rst_n = 1'b0, miso = 1'b0;
  logic ssel_n, sclk, mosi, pins_own, pmem_we, cpu_hold, done;
  logic [AW-1:0] pmem_addr;
  logic [15:0]   pmem_wdata;

  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_boot_loader #(.IMG_WORDS(WORDS), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .miso(miso), .ssel_n(ssel_n), .sclk(sclk),
    .mosi(mosi), .pins_own(pins_own), .pmem_we(pmem_we),
    .pmem_addr(pmem_addr), .pmem_wdata(pmem_wdata), .cpu_hold(cpu_hold),
    .done(done)
  );

  function automatic logic [7:0] rom_byte(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  function automatic logic [15:0] exp_word(input int w);
    return {rom_byte(2 * w + 1), rom_byte(2 * w)};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM, mode 0
  int          ee_cnt = 0;
  logic [23:0] ee_cmd = '0;
  always @(negedge ssel_n) ee_cnt = 0;
  always @(posedge sclk) if (!ssel_n) begin
    if (ee_cnt < 24) ee_cmd = {ee_cmd[22:0], mosi};
    ee_cnt++;
  end
  always @(negedge sclk) if (!ssel_n && ee_cnt >= 24) begin
    int idx;
    idx  = ee_cnt - 24;
    miso = rom_byte(int'(ee_cmd[15:0]) + idx / 8)[7 - idx % 8];
  end

  // port monitor, sampled away from the active edge
  logic [15:0] got [WORDS];
  int n_wr = 0, wr_order_err = 0, wr_nohold = 0, rises = 0, gap_err = 0;
  int last_rise = -1, cyc = 0, ssel_falls = 0, ssel_rises = 0;
  int mosi_err = 0, done_cnt = 0, done_hold_err = 0, done_cyc = -1;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_ssel = 1'b1, p_done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pmem_we) begin
      if (int'(pmem_addr) != n_wr) wr_order_err++;
      if (!cpu_hold) wr_nohold++;
      got[pmem_addr] = pmem_wdata;
      n_wr++;
    end
    if (sclk && !p_sclk) begin
      if (last_rise >= 0 && cyc - last_rise != DIV) gap_err++;
      last_rise = cyc;
      rises++;
    end
    if (mosi != p_mosi && !(p_sclk && !sclk)) mosi_err++;
    if (!ssel_n && p_ssel) ssel_falls++;
    if (ssel_n && !p_ssel) ssel_rises++;
    if (done && !p_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
    if (done && cpu_hold) done_hold_err++;
    p_sclk = sclk; p_mosi = mosi; p_ssel = ssel_n; p_done = done;
  end

  initial begin
    bit wd_hit;
    for (int i = 0; i < WORDS; i++) got[i] = '0;
    repeat (3) @(negedge clk);
    // reset state (R2, R8)
    check("R2 ssel_n in reset", ssel_n, 1);
    check("R1 sclk idle in reset", sclk, 0);
    check("R8 cpu_hold in reset", cpu_hold, 1);
    check("R9 done in reset", done, 0);
    rst_n = 1'b1;

    wd_hit = 1'b1;
    for (int i = 0; i < 20 * NBITS; i++) begin
      @(negedge clk);
      if (done_cnt > 0) begin wd_hit = 1'b0; break; end
    end
    if (wd_hit) check("watchdog: download never completed", 0, 1);

    // stored words against the table
    for (int k = 0; k < 8; k++)
      check("R5 word content", got[PROBE[k]], exp_word(PROBE[k]));

    check("R3 command frame", ee_cmd, 24'h030000);
    check("R4 mosi changes off falling edge", mosi_err, 0);
    check("R6 write count", n_wr, WORDS);
    check("R6 write address order", wr_order_err, 0);
    check("R7 sclk rising edges", rises, NBITS);
    check("R1 R7 sclk period / gaps", gap_err, 0);
    check("R2 ssel_n falls", ssel_falls, 1);
    check("R2 ssel_n rises", ssel_rises, 1);
    check("R8 writes under cpu_hold", wr_nohold, 0);
    check("R9 done while hold high", done_hold_err, 0);

    @(negedge clk);
    check("R9 done width", done, 0);
    check("R8 cpu_hold released", cpu_hold, 0);
    check("R8 pins_own released", pins_own, 0);
    check("R8 sclk parked", sclk, 0);
    check("R8 mosi parked", mosi, 0);
    check("R8 ssel_n parked", ssel_n, 1);

    // idle afterwards (R10)
    repeat (300) @(negedge clk);
    check("R10 no extra writes", n_wr, WORDS);
    check("R10 no extra clocks", rises, NBITS);
    check("R10 single done", done_cnt, 1);
    check("R10 select stays high", ssel_falls, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule